// File: doc/BRIEF.md
# Stepped Frequency Ramp Word Generator

This block produces the digital frequency-control word for a synthesizer that sweeps its output in discrete steps. An internal ramp register holds the current sweep value and moves by one increment on every cycle in which the ramp is active and a step strobe arrives. The strobe comes from an external delay controller, which can therefore hold the sweep at any point, start it late, or pause between sweeps without the generator knowing why.

Two sweep shapes are available. In the linear shape every step adds the same signed deviation, which is the total span divided by the programmed number of steps. In the parabolic shape the increment grows with the step number, so the word moves quadratically. After the programmed number of steps the next strobe returns the word to the start value, and a one-cycle end pulse marks the wrap. This gives a sawtooth. A frequency-shift offset can be added to the ramp value at the output without disturbing the sweep underneath. Clearing the ramp enable parks the generator at the start value.

Top module: `freq_ramp_gen`

## Requirements
- R1: While reset is asserted the step index is 0, the end pulse is low and the ramp register is 0, so `freq_word` equals 0 plus any selected shift.
- R2: With `mode_sel` = 0 (linear), a step with index below `step_count` adds `dev_word` to the ramp register, modulo 2^32 in two's complement, so negative deviations and overflow wrap.
- R3: With `mode_sel` = 1 (parabolic), a step taken at index k (k below `step_count`) adds (k+1) x `dev_word`, truncated to 32 bits, to the ramp register.
- R4: A step taken while the index equals `step_count` loads `start_word` into the ramp register and sets the index to 0. `ramp_end` is high in the following cycle.
- R5: `ramp_end` is high only in the cycle that follows a wrap step. It is low in all other cycles.
- R6: A step happens only in a cycle where both `ramp_en` and `step_en` are high. In all other enabled cycles the index and the ramp register hold.
- R7: In every cycle with `ramp_en` low, the next cycle shows the ramp register equal to that cycle's `start_word`, the index at 0 and `ramp_end` low.
- R8: `freq_word` equals the ramp register plus `fsk_shift` when `fsk_sel` is 1, and the ramp register alone when `fsk_sel` is 0, modulo 2^32. The result follows `fsk_sel` and `fsk_shift` in the same cycle.
- R9: A non-wrap step raises the step index by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ramp_en | input | 1 | Ramp activation; low parks the generator at the start value |
| step_en | input | 1 | Step strobe from the delay controller |
| mode_sel | input | 1 | 0 = linear increment, 1 = parabolic increment |
| fsk_sel | input | 1 | Adds the shift offset to the output word when 1 |
| start_word | input | 32 | Sweep start value |
| dev_word | input | 32 | Signed deviation per step |
| step_count | input | 20 | Number of steps before the wrap |
| fsk_shift | input | 32 | Offset added to the output when selected |
| freq_word | output | 32 | Frequency-control word |
| step_idx | output | 20 | Current step index |
| ramp_end | output | 1 | One-cycle pulse after a wrap |

## Verification
The bench builds the block with its default widths: a 32-bit word, a 20-bit index, and the parabolic path generated. Because the step count is a port, it drives short sweeps of 0, 1, 5 and 6 steps, so many wraps, back-to-back end pulses and the zero-length sweep all occur within a few hundred cycles. Starting the sweep near the top and the bottom of the 32-bit range, with large positive and negative deviations, drives the two's-complement wrap of the ramp register and of the shift adder.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  typedef enum logic {
    RAMP_LINEAR    = 1'b0,
    RAMP_PARABOLIC = 1'b1
  } ramp_mode_e;

  typedef struct packed {
    logic clear;
    logic fire;
  } step_ctl_t;

endpackage

// File: rtl/ramp_step_counter.sv
module ramp_step_counter #(
  parameter int IDX_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ramp_pkg::step_ctl_t ctl,
  input  logic [IDX_W-1:0] step_count,
  output logic [IDX_W-1:0] step_idx,
  output logic             wrap_fire,
  output logic             ramp_end
);

  logic [IDX_W-1:0] idx_q;
  logic             end_q;
  logic             at_last;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] v);
    return v + IDX_W'(1);
  endfunction

  assign at_last   = (idx_q == step_count);
  assign wrap_fire = ctl.fire && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      end_q <= 1'b0;
    end else if (ctl.clear) begin
      idx_q <= '0;
      end_q <= 1'b0;
    end else if (wrap_fire) begin
      idx_q <= '0;
      end_q <= 1'b1;
    end else begin
      end_q <= 1'b0;
      if (ctl.fire) idx_q <= bump(idx_q);
    end
  end

  assign step_idx = idx_q;
  assign ramp_end = end_q;

endmodule

// File: rtl/ramp_increment.sv
module ramp_increment #(
  parameter int WORD_W       = 32,
  parameter int IDX_W        = 20,
  parameter bit PARABOLIC_EN = 1'b1
) (
  input  ramp_pkg::ramp_mode_e mode,
  input  logic [IDX_W-1:0]     step_idx,
  input  logic [WORD_W-1:0]    dev_word,
  output logic [WORD_W-1:0]    inc_word
);

  localparam int PAD_W = WORD_W - IDX_W;

  function automatic logic [WORD_W-1:0] step_number(input logic [IDX_W-1:0] k);
    return {{PAD_W{1'b0}}, k} + WORD_W'(1);
  endfunction

  function automatic logic [WORD_W-1:0] scaled_dev(input logic [WORD_W-1:0] n,
                                                   input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] p;
    p = n * d;
    return p;
  endfunction

  generate
    if (PARABOLIC_EN) begin : g_parabolic
      logic [WORD_W-1:0] grown;
      assign grown    = scaled_dev(step_number(step_idx), dev_word);
      assign inc_word = (mode == ramp_pkg::RAMP_PARABOLIC) ? grown : dev_word;
    end else begin : g_linear_only
      logic unused_sel;
      assign unused_sel = ^{mode, step_idx};
      assign inc_word   = dev_word;
    end
  endgenerate

endmodule

// File: rtl/ramp_accumulator.sv
module ramp_accumulator #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ramp_pkg::step_ctl_t ctl,
  input  logic                wrap_fire,
  input  logic [WORD_W-1:0]   start_word,
  input  logic [WORD_W-1:0]   inc_word,
  output logic [WORD_W-1:0]   acc_q
);

  function automatic logic [WORD_W-1:0] advance(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] d);
    return a + d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (ctl.clear)        acc_q <= start_word;
    else if (wrap_fire)        acc_q <= start_word;
    else if (ctl.fire)         acc_q <= advance(acc_q, inc_word);
  end

endmodule

// File: rtl/fsk_overlay.sv
module fsk_overlay #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] ramp_word,
  input  logic              fsk_sel,
  input  logic [WORD_W-1:0] fsk_shift,
  output logic [WORD_W-1:0] out_word
);

  function automatic logic [WORD_W-1:0] overlay(input logic [WORD_W-1:0] r,
                                                input logic s,
                                                input logic [WORD_W-1:0] f);
    return s ? (r + f) : r;
  endfunction

  assign out_word = overlay(ramp_word, fsk_sel, fsk_shift);

endmodule

// File: rtl/freq_ramp_gen.sv
module freq_ramp_gen #(
  parameter int WORD_W       = 32,
  parameter int IDX_W        = 20,
  parameter bit PARABOLIC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ramp_en,
  input  logic              step_en,
  input  logic              mode_sel,
  input  logic              fsk_sel,
  input  logic [WORD_W-1:0] start_word,
  input  logic [WORD_W-1:0] dev_word,
  input  logic [IDX_W-1:0]  step_count,
  input  logic [WORD_W-1:0] fsk_shift,
  output logic [WORD_W-1:0] freq_word,
  output logic [IDX_W-1:0]  step_idx,
  output logic              ramp_end
);

  ramp_pkg::step_ctl_t  ctl;
  ramp_pkg::ramp_mode_e mode;
  logic                 step_fire;
  logic                 wrap_fire;
  logic [WORD_W-1:0]    inc_word;
  logic [WORD_W-1:0]    acc_q;

  assign step_fire = ramp_en && step_en;
  assign ctl.clear = !ramp_en;
  assign ctl.fire  = step_fire;
  assign mode      = ramp_pkg::ramp_mode_e'(mode_sel);

  ramp_step_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .step_count(step_count),
    .step_idx  (step_idx),
    .wrap_fire (wrap_fire),
    .ramp_end  (ramp_end)
  );

  ramp_increment #(
    .WORD_W      (WORD_W),
    .IDX_W       (IDX_W),
    .PARABOLIC_EN(PARABOLIC_EN)
  ) u_inc (
    .mode    (mode),
    .step_idx(step_idx),
    .dev_word(dev_word),
    .inc_word(inc_word)
  );

  ramp_accumulator #(.WORD_W(WORD_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .wrap_fire (wrap_fire),
    .start_word(start_word),
    .inc_word  (inc_word),
    .acc_q     (acc_q)
  );

  fsk_overlay #(.WORD_W(WORD_W)) u_fsk (
    .ramp_word(acc_q),
    .fsk_sel  (fsk_sel),
    .fsk_shift(fsk_shift),
    .out_word (freq_word)
  );

endmodule

// File: rtl/ramp_checker.sv
module ramp_checker #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ramp_en,
  input logic              step_en,
  input logic              mode_sel,
  input logic [WORD_W-1:0] start_word,
  input logic [WORD_W-1:0] dev_word,
  input logic [IDX_W-1:0]  step_count,
  input logic [IDX_W-1:0]  step_idx,
  input logic              ramp_end,
  input logic [WORD_W-1:0] acc_q,
  input logic              step_fire,
  input logic              wrap_fire
);

  a_r2_linear_add: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && !wrap_fire && !mode_sel |=> acc_q == $past(acc_q) + $past(dev_word));

  a_r4_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en && step_en && step_idx == step_count
      |=> step_idx == '0 && ramp_end && acc_q == $past(start_word));

  a_r5_end_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_end |-> $past(wrap_fire));

  a_r6_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en && !step_en |=> $stable(step_idx) && $stable(acc_q));

  a_r7_park_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_en |=> step_idx == '0 && !ramp_end && acc_q == $past(start_word));

  a_r9_index_bump: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire && !wrap_fire |=> step_idx == $past(step_idx) + IDX_W'(1));

endmodule

bind freq_ramp_gen ramp_checker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_ramp_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ramp_en   (ramp_en),
  .step_en   (step_en),
  .mode_sel  (mode_sel),
  .start_word(start_word),
  .dev_word  (dev_word),
  .step_count(step_count),
  .step_idx  (step_idx),
  .ramp_end  (ramp_end),
  .acc_q     (acc_q),
  .step_fire (step_fire),
  .wrap_fire (wrap_fire)
);

// File: tb/test_freq_ramp_gen.sv
module test_freq_ramp_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ramp_en = 1'b0, step_en = 1'b0, mode_sel = 1'b0, fsk_sel = 1'b0;
  logic [31:0] start_word = '0, dev_word = '0, fsk_shift = '0;
  logic [19:0] step_count = '0;
  logic [31:0] freq_word;
  logic [19:0] step_idx;
  logic        ramp_end;

  int    n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference state
  bit [31:0] m_ramp;
  int        m_idx;
  bit        m_end;

  always #10 clk = ~clk;  // 50 MHz

  freq_ramp_gen i_freq_ramp_gen (
    .clk(clk), .rst_n(rst_n), .ramp_en(ramp_en), .step_en(step_en),
    .mode_sel(mode_sel), .fsk_sel(fsk_sel), .start_word(start_word),
    .dev_word(dev_word), .step_count(step_count), .fsk_shift(fsk_shift),
    .freq_word(freq_word), .step_idx(step_idx), .ramp_end(ramp_end)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ramp = 0; m_idx = 0; m_end = 0;
    end else if (!ramp_en) begin
      m_ramp = start_word; m_idx = 0; m_end = 0;
    end else if (step_en && m_idx == int'(step_count)) begin
      m_ramp = start_word; m_idx = 0; m_end = 1;
    end else if (step_en) begin
      longint unsigned grow;
      grow   = mode_sel ? (longint'(m_idx) + 1) * longint'(dev_word) : longint'(dev_word);
      m_ramp = m_ramp + grow[31:0];
      m_idx  = m_idx + 1;
      m_end  = 0;
    end else begin
      m_end = 0;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit [31:0] want;
    want = fsk_sel ? m_ramp + fsk_shift : m_ramp;
    check(cur_req, "freq_word", longint'(freq_word), longint'(want));
    check(cur_req, "step_idx", longint'(step_idx), longint'(m_idx));
    check(m_end ? "R4" : "R5", "ramp_end", longint'(ramp_end), longint'(m_end));
  endtask

  task automatic tick(bit strobe);
    step_en = strobe;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    int ends;
    // R1: reset values
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "reset step_idx", longint'(step_idx), 0);
    check("R1", "reset ramp_end", longint'(ramp_end), 0);
    check("R1", "reset freq_word", longint'(freq_word), 0);
    rst_n = 1'b1;

    // R7: parked while disabled, follows start
    cur_req = "R7";
    start_word = 32'd1000; dev_word = 32'd7; step_count = 20'd5;
    tick(1); tick(1);
    start_word = 32'd2000;
    tick(1);
    check("R7", "parked word", longint'(freq_word), 2000);

    // R2 / R9 / R4: linear sweep, strobe every cycle
    cur_req = "R2"; ramp_en = 1'b1;
    for (int i = 0; i < 20; i++) tick(1);
    cur_req = "R9";
    for (int i = 0; i < 3; i++) tick(1);
    check("R9", "index after steps", longint'(step_idx), longint'(m_idx));

    // R6: strobe every third cycle
    cur_req = "R6";
    for (int i = 0; i < 24; i++) tick(i % 3 == 0);
    tick(0);
    check("R6", "held index", longint'(step_idx), longint'(m_idx));

    // R2: negative deviation across zero, and overflow at the top
    cur_req = "R2";
    ramp_en = 1'b0; start_word = 32'd10; dev_word = -32'sd4; tick(0);
    ramp_en = 1'b1;
    for (int i = 0; i < 12; i++) tick(1);
    ramp_en = 1'b0; start_word = 32'hFFFF_FFF0; dev_word = 32'h4000_0003; tick(0);
    ramp_en = 1'b1;
    for (int i = 0; i < 12; i++) tick(1);

    // R8: shift overlay toggled mid-sweep, with overflow
    cur_req = "R8"; fsk_shift = 32'h8000_0001;
    for (int i = 0; i < 16; i++) begin
      fsk_sel = (i % 4) >= 2;
      tick(i % 2 == 0);
    end
    fsk_sel = 1'b1; fsk_shift = 32'd55; #1;
    check("R8", "same-cycle overlay", longint'(freq_word), longint'(32'(m_ramp + 32'd55)));
    fsk_sel = 1'b0;

    // R3: parabolic sweep with 6 steps, positive then negative deviation
    cur_req = "R3";
    ramp_en = 1'b0; mode_sel = 1'b1; start_word = 32'd100; dev_word = 32'd3;
    step_count = 20'd6; tick(0);
    ramp_en = 1'b1;
    for (int i = 0; i < 6; i++) tick(1);
    check("R3", "parabolic top", longint'(freq_word), 100 + 3 * 21);
    for (int i = 0; i < 20; i++) tick(i % 5 != 4);
    dev_word = -32'sd1000;
    for (int i = 0; i < 20; i++) tick(1);

    // R4 / R5: zero-length and one-step sweeps
    cur_req = "R4"; mode_sel = 1'b0; step_count = 20'd0; dev_word = 32'd9;
    ends = 0;
    for (int i = 0; i < 8; i++) begin
      tick(i != 3);
      ends += int'(ramp_end);
    end
    check("R4", "end pulses with zero steps", longint'(ends), 7);
    cur_req = "R5"; step_count = 20'd1;
    for (int i = 0; i < 10; i++) tick(1);

    // R7: disable in the middle of a sweep
    cur_req = "R7"; step_count = 20'd50;
    for (int i = 0; i < 5; i++) tick(1);
    ramp_en = 1'b0; start_word = 32'h1234_5678;
    tick(1);
    check("R7", "cleared index", longint'(step_idx), 0);
    check("R7", "restart word", longint'(freq_word), 32'h1234_5678);
    ramp_en = 1'b1;
    for (int i = 0; i < 4; i++) tick(1);

    finish_run();
  end

endmodule